// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block drives the strobes of a microcontroller's external memory bus. It produces the bus clock, the address latch pulse, the active-low code fetch strobe, the read strobe and the write strobe. A requester asks for one cycle at a time and states the cycle kind: code fetch, data read or data write. It also states whether the cycle opens with an address latch phase and whether the fetch is part of a burst. The sequencer runs on an internal clock at twice the bus clock rate. One internal tick is therefore half a bus clock, and every programmed width is a whole number of ticks.

Four 2-bit length fields size the cycles: code without latch, code with latch, data without latch and data with latch. Writes use the data fields. One more bit picks a short or a long latch pulse. The strobe phase fills whatever remains of the programmed total, and it never drops below one bus clock. A wait input stretches the strobe phase one bus clock at a time. At the end of a read the sequencer captures the read bus and raises a one-tick done pulse. During a burst, the fetch strobe stays low between consecutive fetches.

Top module: `bus_seq`

## Requirements
- R1: The bus clock output is low in reset and toggles on every internal tick. A bus clock rising edge is an internal edge at which it goes from 0 to 1.
- R2: A code fetch without a latch phase (req_kind 00) holds fetch_n_o low for 2*(f+1) ticks, where f is cfg_code_nl. Done follows 2*(f+1) ticks after the first busy tick.
- R3: In a cycle with a latch phase, ale_o is high for 1 tick when cfg_long_latch is 0 and for 3 ticks when it is 1. A one-tick gap follows, and the strobe phase starts after that gap.
- R4: A cycle with a latch phase lasts 2*(f+2) ticks in total, using cfg_code_l or cfg_data_l as f. Its strobe phase lasts the total minus the latch width minus one tick, but never less than 2 ticks.
- R5: A data read (req_kind 01) holds rd_n_o low for the strobe phase. Its length comes from cfg_data_nl, or from cfg_data_l when it has a latch phase, using the same encodings as code fetches.
- R6: A write (req_kind 1x) uses the data fields. wr_n_o goes low one tick after the strobe phase begins, while the bus clock is low, and goes high at the end of the cycle.
- R7: wait_i is sampled at the rising edge that would end the strobe phase. Each time it is high there, the strobe phase grows by 2 ticks.
- R8: On the rising edge that ends a code fetch or a data read, rdata_i is captured into rdata_o. A write leaves rdata_o unchanged. done_o is high for exactly one tick after the last edge of every cycle.
- R9: The length fields and the latch width bit are taken when a cycle starts. Changing them during a cycle does not change that cycle.
- R10: When a code fetch with req_burst set ends, fetch_n_o stays low until the next cycle starts. The fetch strobe rises at the end of the first code fetch issued with req_burst clear.
- R11: In reset, ale_o and done_o are low, every strobe is high and busy_o is low.
- R12: A request is accepted only when the sequencer is idle, at a bus clock rising edge. busy_o rises on that edge and stays high until the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_code_nl | input | FW | Code fetch length field, no latch phase |
| cfg_code_l | input | FW | Code fetch length field, with latch phase |
| cfg_data_nl | input | FW | Data cycle length field, no latch phase |
| cfg_data_l | input | FW | Data cycle length field, with latch phase |
| cfg_long_latch | input | 1 | 1 selects the 1.5 clock latch pulse, 0 selects 0.5 clock |
| req_i | input | 1 | Cycle request, held until busy_o is seen |
| req_kind | input | 2 | 00 code fetch, 01 data read, 1x data write |
| req_latch | input | 1 | Cycle opens with an address latch phase |
| req_burst | input | 1 | Code fetch continues a burst |
| wait_i | input | 1 | Stretch request for the strobe phase |
| rdata_i | input | DW | Read data bus |
| bus_clk_o | output | 1 | Bus clock |
| ale_o | output | 1 | Address latch enable |
| fetch_n_o | output | 1 | Code fetch strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-tick pulse after a cycle ends |
| rdata_o | output | DW | Data captured at the end of the last read |

## Verification
Every output comes straight from a register that changes on the accepting or ending edge, so each result is due in a known tick. The bench samples on the falling internal clock edge and numbers ticks from the first tick in which busy_o is high. Tick 0 is the first tick of the cycle. The latch pulse runs from tick 0, the strobe starts at the tick index the requirements give, and done_o together with the new rdata_o appears at the tick whose index equals the total cycle length. The tick after that must show done_o low again. wait_i is driven from the count of strobe ticks already observed, so each extension lands on the edge that would otherwise end the cycle.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LATCH = 2'd1,
    ST_GAP   = 2'd2,
    ST_STRB  = 2'd3
  } seq_st_e;

  localparam logic [1:0] KIND_CODE = 2'b00;
  localparam logic [1:0] KIND_READ = 2'b01;

  // ticks needed to hold the longest programmable cycle for a field width
  function automatic int cnt_width(input int fw);
    return $clog2(2 * ((1 << fw) + 1) + 1);
  endfunction
endpackage

// File: rtl/bus_len_calc.sv
module bus_len_calc
  import bus_seq_pkg::*;
#(
  parameter int FW = 2,
  parameter int CW = cnt_width(FW)
) (
  input  logic          is_code,
  input  logic          latch,
  input  logic          long_latch,
  input  logic [FW-1:0] f_code_nl,
  input  logic [FW-1:0] f_code_l,
  input  logic [FW-1:0] f_data_nl,
  input  logic [FW-1:0] f_data_l,
  output logic [CW-1:0] lat_ticks,
  output logic [CW-1:0] strb_ticks
);
  logic [FW-1:0] sel;
  logic [CW-1:0] total;

  always_comb begin
    if (is_code) sel = latch ? f_code_l : f_code_nl;
    else         sel = latch ? f_data_l : f_data_nl;
    // one extra clock for the latch phase, two ticks per clock
    total     = (CW'(sel) + (latch ? CW'(2) : CW'(1))) << 1;
    lat_ticks = long_latch ? CW'(3) : CW'(1);
    if (!latch)                           strb_ticks = total;
    else if (total >= lat_ticks + CW'(3)) strb_ticks = total - lat_ticks - CW'(1);
    else                                  strb_ticks = CW'(2);
  end
endmodule

// File: rtl/bus_clk_gen.sv
module bus_clk_gen (
  input  logic clk,
  input  logic rst_n,
  output logic ph_o
);
  logic ph_q, ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign ph_o = ph_q;
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int FW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] cfg_code_nl,
  input  logic [FW-1:0] cfg_code_l,
  input  logic [FW-1:0] cfg_data_nl,
  input  logic [FW-1:0] cfg_data_l,
  input  logic          cfg_long_latch,
  input  logic          req_i,
  input  logic [1:0]    req_kind,
  input  logic          req_latch,
  input  logic          req_burst,
  input  logic          wait_i,
  input  logic [DW-1:0] rdata_i,
  output logic          bus_clk_o,
  output logic          ale_o,
  output logic          fetch_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  localparam int CW = cnt_width(FW);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, strb_q, strb_d;
  logic [1:0]    kind_q, kind_d;
  logic          burst_q, burst_d, hold_q, hold_d;
  logic          first_q, first_d, done_q, done_d;
  logic [DW-1:0] rdata_q;
  logic          rdata_en, ph, start;
  logic [CW-1:0] lat_ticks, strb_ticks;
  logic          strobe, is_code_q, is_read_q, is_wr_q;

  bus_clk_gen u_clk (.clk(clk), .rst_n(rst_n), .ph_o(ph));

  bus_len_calc #(.FW(FW), .CW(CW)) u_len (
    .is_code    (req_kind == KIND_CODE),
    .latch      (req_latch),
    .long_latch (cfg_long_latch),
    .f_code_nl  (cfg_code_nl),
    .f_code_l   (cfg_code_l),
    .f_data_nl  (cfg_data_nl),
    .f_data_l   (cfg_data_l),
    .lat_ticks  (lat_ticks),
    .strb_ticks (strb_ticks)
  );

  // ph low now means the coming edge is a bus clock rising edge
  assign start = (st_q == ST_IDLE) && req_i && !ph;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    strb_d   = strb_q;
    kind_d   = kind_q;
    burst_d  = burst_q;
    hold_d   = hold_q;
    first_d  = 1'b0;
    done_d   = 1'b0;
    rdata_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        kind_d  = req_kind;
        burst_d = req_burst;
        strb_d  = strb_ticks;
        hold_d  = 1'b0;
        if (req_latch) begin
          st_d  = ST_LATCH;
          cnt_d = lat_ticks - CW'(1);
        end else begin
          st_d    = ST_STRB;
          cnt_d   = strb_ticks - CW'(1);
          first_d = 1'b1;
        end
      end
      ST_LATCH: begin
        if (cnt_q == '0) st_d = ST_GAP;
        else             cnt_d = cnt_q - CW'(1);
      end
      ST_GAP: begin
        st_d    = ST_STRB;
        cnt_d   = strb_q - CW'(1);
        first_d = 1'b1;
      end
      ST_STRB: begin
        if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
        else if (wait_i)  cnt_d = CW'(1);
        else begin
          st_d     = ST_IDLE;
          done_d   = 1'b1;
          hold_d   = burst_q && (kind_q == KIND_CODE);
          rdata_en = !kind_q[1];
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      strb_q  <= '0;
      kind_q  <= KIND_CODE;
      burst_q <= 1'b0;
      hold_q  <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      strb_q  <= strb_d;
      kind_q  <= kind_d;
      burst_q <= burst_d;
      hold_q  <= hold_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_i;
  end

  assign strobe    = (st_q == ST_STRB);
  assign is_code_q = (kind_q == KIND_CODE);
  assign is_read_q = (kind_q == KIND_READ);
  assign is_wr_q   = kind_q[1];

  assign bus_clk_o = ph;
  assign ale_o     = (st_q == ST_LATCH);
  assign fetch_n_o = !((strobe && is_code_q) || hold_q);
  assign rd_n_o    = !(strobe && is_read_q);
  assign wr_n_o    = !(strobe && is_wr_q && !first_q);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_clk_o,
  input logic ale_o,
  input logic fetch_n_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic busy_o,
  input logic done_o
);
  a_r1_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_clk_o != $past(bus_clk_o)));

  a_r3_ale_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale_o) |-> bus_clk_o);

  a_r3_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (fetch_n_o && rd_n_o && wr_n_o));

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~fetch_n_o, ~rd_n_o, ~wr_n_o}) <= 1);

  a_r5_rd_edges: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n_o) || $rose(rd_n_o)) |-> bus_clk_o);

  a_r6_wr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n_o) |-> !bus_clk_o);

  a_r6_wr_end_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n_o) |-> bus_clk_o);

  a_r2_fetch_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_n_o) |-> bus_clk_o);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bus_clk_o && !busy_o));

  a_r12_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> bus_clk_o);
endmodule

bind bus_seq bus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_clk_o (bus_clk_o),
  .ale_o     (ale_o),
  .fetch_n_o (fetch_n_o),
  .rd_n_o    (rd_n_o),
  .wr_n_o    (wr_n_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/bus_seq_bench.sv
module bus_seq_bench;
  localparam int PERIOD = 10;

  logic       clk, rst_n;
  logic [1:0] cfg_code_nl, cfg_code_l, cfg_data_nl, cfg_data_l;
  logic       cfg_long_latch, req_i, req_latch, req_burst, wait_i;
  logic [1:0] req_kind;
  logic [7:0] rdata_i, rdata_o;
  logic       bus_clk_o, ale_o, fetch_n_o, rd_n_o, wr_n_o, busy_o, done_o;

  int errs = 0;
  int nchk = 0;

  bus_seq #(.FW(2), .DW(8)) u_bus_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_code_nl(cfg_code_nl), .cfg_code_l(cfg_code_l),
    .cfg_data_nl(cfg_data_nl), .cfg_data_l(cfg_data_l),
    .cfg_long_latch(cfg_long_latch),
    .req_i(req_i), .req_kind(req_kind), .req_latch(req_latch), .req_burst(req_burst),
    .wait_i(wait_i), .rdata_i(rdata_i),
    .bus_clk_o(bus_clk_o), .ale_o(ale_o), .fetch_n_o(fetch_n_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0] kind;
    logic       lat;
    logic       longl;
    logic [1:0] fld;
    logic [1:0] nw;
    logic [3:0] e_ale;
    logic [3:0] e_str;
    logic [3:0] e_first;
    logic [3:0] e_tot;
  } vec_t;

  localparam vec_t VECS [0:11] = '{
    '{2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0, 4'd2, 4'd0, 4'd2},
    '{2'd0, 1'b0, 1'b0, 2'd3, 2'd0, 4'd0, 4'd8, 4'd0, 4'd8},
    '{2'd0, 1'b1, 1'b0, 2'd0, 2'd0, 4'd1, 4'd2, 4'd2, 4'd4},
    '{2'd0, 1'b1, 1'b1, 2'd2, 2'd0, 4'd3, 4'd4, 4'd4, 4'd8},
    '{2'd0, 1'b1, 1'b1, 2'd0, 2'd0, 4'd3, 4'd2, 4'd4, 4'd6},
    '{2'd1, 1'b0, 1'b0, 2'd1, 2'd0, 4'd0, 4'd4, 4'd0, 4'd4},
    '{2'd1, 1'b1, 1'b0, 2'd3, 2'd0, 4'd1, 4'd8, 4'd2, 4'd10},
    '{2'd2, 1'b0, 1'b0, 2'd1, 2'd0, 4'd0, 4'd3, 4'd1, 4'd4},
    '{2'd2, 1'b1, 1'b1, 2'd1, 2'd0, 4'd3, 4'd1, 4'd5, 4'd6},
    '{2'd1, 1'b0, 1'b0, 2'd0, 2'd2, 4'd0, 4'd6, 4'd0, 4'd6},
    '{2'd0, 1'b1, 1'b0, 2'd1, 2'd1, 4'd1, 4'd6, 4'd2, 4'd8},
    '{2'd2, 1'b0, 1'b0, 2'd2, 2'd1, 4'd0, 4'd7, 4'd1, 4'd8}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_cycle(input logic [1:0] k, input logic lat, input logic bst,
                          input int thr, input logic poke, input logic [7:0] dat,
                          output int ale_c, output int str_c, output int first_i,
                          output int tot, output logic bclk0, output logic bclk_first,
                          output int fh, output logic f_done);
    bit started = 0;
    int idx = 0;
    logic s;
    ale_c = 0; str_c = 0; first_i = -1; tot = -1; fh = 0;
    bclk0 = 1'b0; bclk_first = 1'b0; f_done = 1'b0;
    @(negedge clk);
    req_kind = k; req_latch = lat; req_burst = bst; rdata_i = dat; req_i = 1'b1;
    for (int g = 0; g < 64; g++) begin
      @(negedge clk);
      if (!started && busy_o) begin
        started = 1;
        req_i = 1'b0;
        bclk0 = bus_clk_o;
        if (poke) cfg_code_nl = 2'd3;
      end
      if (started && done_o) begin
        tot = idx;
        f_done = fetch_n_o;
        break;
      end
      if (fetch_n_o) fh++;
      if (started) begin
        if (ale_o) ale_c++;
        s = (k == 2'd0) ? !fetch_n_o : (k[1] ? !wr_n_o : !rd_n_o);
        if (s) begin
          if (first_i < 0) begin
            first_i = idx;
            bclk_first = bus_clk_o;
          end
          str_c++;
        end
        idx++;
      end
      wait_i = started && (str_c < thr);
    end
    wait_i = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errs++;
    nchk++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    int ale_c, str_c, first_i, tot, fh;
    logic bclk0, bclk_first, f_done, prev;
    logic [7:0] last_rd;
    string tg;

    rst_n = 1'b0; req_i = 1'b0; req_kind = 2'd0; req_latch = 1'b0; req_burst = 1'b0;
    wait_i = 1'b0; rdata_i = 8'h00; cfg_long_latch = 1'b0;
    cfg_code_nl = 2'd0; cfg_code_l = 2'd0; cfg_data_nl = 2'd0; cfg_data_l = 2'd0;
    repeat (3) @(negedge clk);

    // R11 reset state, R1 bus clock low in reset
    chk(!ale_o && !done_o && !busy_o, "R11 ale/done/busy", {ale_o, done_o, busy_o}, 0);
    chk(fetch_n_o && rd_n_o && wr_n_o, "R11 strobes", {fetch_n_o, rd_n_o, wr_n_o}, 7);
    chk(bus_clk_o == 1'b0, "R1 reset clk", bus_clk_o, 0);
    rst_n = 1'b1;

    // R1 toggle each tick
    @(negedge clk);
    prev = bus_clk_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(bus_clk_o != prev, "R1 toggle", bus_clk_o, !prev);
      prev = bus_clk_o;
    end

    last_rd = 8'h00;
    for (int i = 0; i < 12; i++) begin
      vec_t v;
      v = VECS[i];
      cfg_code_nl = v.fld; cfg_code_l = v.fld; cfg_data_nl = v.fld; cfg_data_l = v.fld;
      cfg_long_latch = v.longl;
      if (v.nw != 0)           tg = "R7";
      else if (v.kind[1])      tg = "R6";
      else if (v.kind == 2'd1) tg = "R5";
      else if (v.lat)          tg = "R4";
      else                     tg = "R2";
      do_cycle(v.kind, v.lat, 1'b0, int'(v.e_str), 1'b0, 8'h30 + 8'(i),
               ale_c, str_c, first_i, tot, bclk0, bclk_first, fh, f_done);
      chk(ale_c == int'(v.e_ale), "R3 latch width", ale_c, v.e_ale);
      chk(str_c == int'(v.e_str), {tg, " strobe ticks"}, str_c, v.e_str);
      chk(first_i == int'(v.e_first), {tg, " strobe start"}, first_i, v.e_first);
      chk(tot == int'(v.e_tot), {tg, " total"}, tot, v.e_tot);
      chk(bclk0 == 1'b1, "R12 start on rise", bclk0, 1);
      chk(bclk_first == !v.kind[1], "R6 strobe edge", bclk_first, !v.kind[1]);
      if (!v.kind[1]) last_rd = 8'h30 + 8'(i);
      chk(rdata_o == last_rd, "R8 read data", rdata_o, last_rd);
      @(negedge clk);
      chk(!done_o, "R8 done one tick", done_o, 0);
    end

    // R9: field change during a cycle is ignored, used by the next cycle
    cfg_code_nl = 2'd0; cfg_long_latch = 1'b0;
    do_cycle(2'd0, 1'b0, 1'b0, 2, 1'b1, 8'h55,
             ale_c, str_c, first_i, tot, bclk0, bclk_first, fh, f_done);
    chk(str_c == 2, "R9 old field kept", str_c, 2);
    chk(tot == 2, "R9 old total", tot, 2);
    do_cycle(2'd0, 1'b0, 1'b0, 8, 1'b0, 8'h56,
             ale_c, str_c, first_i, tot, bclk0, bclk_first, fh, f_done);
    chk(str_c == 8, "R9 new field used", str_c, 8);

    // R10: burst fetch keeps the fetch strobe low across cycle boundaries
    cfg_code_nl = 2'd0; cfg_code_l = 2'd0;
    do_cycle(2'd0, 1'b1, 1'b1, 2, 1'b0, 8'h61,
             ale_c, str_c, first_i, tot, bclk0, bclk_first, fh, f_done);
    chk(f_done == 1'b0, "R10 held after first", f_done, 0);
    do_cycle(2'd0, 1'b0, 1'b1, 2, 1'b0, 8'h62,
             ale_c, str_c, first_i, tot, bclk0, bclk_first, fh, f_done);
    chk(fh == 0, "R10 no gap before second", fh, 0);
    chk(f_done == 1'b0, "R10 held after second", f_done, 0);
    do_cycle(2'd0, 1'b0, 1'b0, 2, 1'b0, 8'h63,
             ale_c, str_c, first_i, tot, bclk0, bclk_first, fh, f_done);
    chk(fh == 0, "R10 no gap before last", fh, 0);
    chk(f_done == 1'b1, "R10 released at end", f_done, 1);
    chk(rdata_o == 8'h63, "R8 burst data", rdata_o, 8'h63);
    repeat (3) begin
      @(negedge clk);
      chk(fetch_n_o == 1'b1, "R10 stays released", fetch_n_o, 1);
    end

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule